// File: doc/BRIEF.md
# RAM Segment Address Sweep Generator

This block produces the read address for a waveform or frequency lookup RAM. A bank of four profile control words (sweep mode, lower address, upper address, step interval) is written into a shadow copy through buffered inputs. The copy becomes active only on a rising edge of the update strobe. The active word is chosen by two profile-select pins. A reloadable down-counter paces the address steps. The sweep pattern depends on the 3-bit mode of the active word.

Four patterns are offered. The first is a one-shot climb that parks at the upper address. The second is a sweep steered by an external direction pin. The third is an automatic up/down triangle. The fourth is an automatic sawtooth that wraps back to the lower address. A sweep restarts from the lower address on an update edge or on a change of the profile pins. A step strobe marks every address change, and an end flag reports a parked or stalled sweep. Lowering the RAM-enable input freezes the sweep.

Top module: `ram_sweep_gen`

## Requirements
- R1: After reset, addr_o is 0 and step_o and end_o are low. Neither changes until the first restart event.
- R2: A restart is caused by a rising edge of update_i, not by its level. On that edge the four buffered profile words are copied into the active set. One clock later addr_o equals the lower address of the selected word and the step counter is loaded.
- R3: Outside steered mode, a change on prof_sel_i restarts the sweep one clock later, using the newly selected word. Profile p's fields sit at seg_mode_i[3p+:3], seg_begin_i[10p+:10], seg_final_i[10p+:10] and seg_rate_i[16p+:16].
- R4: With step interval N, the address moves once every N clocks, and the first move comes N clocks after the load. An interval of 0 behaves as 1. step_o is high for exactly the one cycle after each address change.
- R5: Mode 000 climbs by one per step to the upper address and parks there, with end_o high while parked. The unused codes 010, 101, 110 and 111 behave the same way.
- R6: Mode 001 is steered: dir_i high counts up and dir_i low counts down. The sweep stalls at the upper address (going up) or at the lower address (going down), and end_o is high while stalled.
- R7: In mode 001, a change of dir_i moves the address one step in the new direction at the next clock and reloads the step counter.
- R8: When profile 0 holds mode 001, profile 0's word governs the sweep whatever prof_sel_i is, and changes on prof_sel_i cause no restart.
- R9: Mode 011 counts from the lower address up to the upper address, then down to the lower address, and repeats.
- R10: Mode 100 counts up to the upper address and then jumps back to the lower address on the next step, and repeats.
- R11: A dir_i change never transfers buffered profile words. New words take effect only after an update edge.
- R12: While ram_en_i is low, addr_o holds and step_o stays low. Restart events seen during that time are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ram_en_i | input | 1 | Sweep enable; low freezes the sweep |
| update_i | input | 1 | Transfer strobe; acts on its rising edge |
| prof_sel_i | input | 2 | Profile select |
| dir_i | input | 1 | Direction for steered mode (1 = up) |
| seg_mode_i | input | 12 | Buffered 3-bit mode per profile |
| seg_begin_i | input | 40 | Buffered lower address per profile |
| seg_final_i | input | 40 | Buffered upper address per profile |
| seg_rate_i | input | 64 | Buffered step interval per profile |
| addr_o | output | 10 | RAM read address |
| step_o | output | 1 | High the cycle after an address change |
| end_o | output | 1 | Sweep parked or stalled at a limit |

## Verification
The hardest situations to reach are the steered-mode corners. One is a direction flip that lands on the same clock as a counter expiry. Another is a flip while the sweep is stalled at a limit. A third is a profile-select change that must be ignored because profile 0 is locked in steered mode. To reach them, the stimulus first parks the sweep at the upper address with a slow interval. It then toggles dir_i on consecutive clocks, and moves prof_sel_i while profile 0 is steered. Afterwards it rewrites the buffered words without an update edge, so that any leak into the active set would show up as a jump in addr_o.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    SEG_RAMP   = 3'b000,
    SEG_STEER  = 3'b001,
    SEG_BOUNCE = 3'b011,
    SEG_WRAP   = 3'b100
  } seg_mode_e;

  function automatic logic is_steer(input logic [MODE_W-1:0] m);
    return m == SEG_STEER;
  endfunction

  function automatic logic is_ramp(input logic [MODE_W-1:0] m);
    return (m != SEG_STEER) && (m != SEG_BOUNCE) && (m != SEG_WRAP);
  endfunction
endpackage

// File: rtl/sweep_ctrl.sv
module sweep_ctrl #(
  parameter int PW = 2
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          ram_en_i,
  input  logic          update_i,
  input  logic [PW-1:0] prof_sel_i,
  input  logic          dir_i,
  input  logic          lock_i,
  output logic          upd_rise_o,
  output logic [PW-1:0] prof_o,
  output logic          restart_o,
  output logic          dir_flip_o
);
  logic          upd_q;
  logic          dir_q;
  logic [PW-1:0] prof_q;
  logic          prof_chg;

  assign upd_rise_o = update_i & ~upd_q;
  assign prof_chg   = prof_sel_i != prof_q;
  assign dir_flip_o = dir_i ^ dir_q;
  assign prof_o     = prof_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      upd_q     <= 1'b0;
      dir_q     <= 1'b0;
      prof_q    <= '0;
      restart_o <= 1'b0;
    end else begin
      upd_q     <= update_i;
      dir_q     <= dir_i;
      prof_q    <= prof_sel_i;
      restart_o <= ram_en_i & (upd_rise_o | (prof_chg & ~lock_i));
    end
  end
endmodule

// File: rtl/sweep_bank.sv
module sweep_bank
  import sweep_pkg::*;
#(
  parameter int NPROF = 4,
  parameter int AW    = 10,
  parameter int RW    = 16,
  parameter int PW    = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  load_i,
  input  logic [NPROF*MODE_W-1:0] mode_i,
  input  logic [NPROF*AW-1:0]   begin_i,
  input  logic [NPROF*AW-1:0]   final_i,
  input  logic [NPROF*RW-1:0]   rate_i,
  input  logic [PW-1:0]         sel_i,
  output logic [MODE_W-1:0]     cur_mode_o,
  output logic [AW-1:0]         cur_begin_o,
  output logic [AW-1:0]         cur_final_o,
  output logic [RW-1:0]         cur_rate_o,
  output logic                  lock_o
);
  logic [MODE_W-1:0] mode_a  [NPROF];
  logic [AW-1:0]     begin_a [NPROF];
  logic [AW-1:0]     final_a [NPROF];
  logic [RW-1:0]     rate_a  [NPROF];
  logic [PW-1:0]     eff;
  logic [RW-1:0]     raw_rate;

  for (genvar p = 0; p < NPROF; p++) begin : g_prof
    logic [MODE_W-1:0] mode_r;
    logic [AW-1:0]     begin_r;
    logic [AW-1:0]     final_r;
    logic [RW-1:0]     rate_r;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        mode_r  <= '0;
        begin_r <= '0;
        final_r <= '0;
        rate_r  <= '0;
      end else if (load_i) begin
        mode_r  <= mode_i[p*MODE_W +: MODE_W];
        begin_r <= begin_i[p*AW +: AW];
        final_r <= final_i[p*AW +: AW];
        rate_r  <= rate_i[p*RW +: RW];
      end
    end

    assign mode_a[p]  = mode_r;
    assign begin_a[p] = begin_r;
    assign final_a[p] = final_r;
    assign rate_a[p]  = rate_r;
  end

  // Steered mode on profile 0 takes over the whole bank
  assign lock_o      = is_steer(mode_a[0]);
  assign eff         = lock_o ? '0 : sel_i;
  assign cur_mode_o  = mode_a[eff];
  assign cur_begin_o = begin_a[eff];
  assign cur_final_o = final_a[eff];
  assign raw_rate    = rate_a[eff];
  assign cur_rate_o  = (raw_rate == '0) ? RW'(1) : raw_rate;
endmodule

// File: rtl/sweep_timer.sv
module sweep_timer #(
  parameter int RW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          hold_i,
  input  logic          load_i,
  input  logic [RW-1:0] rate_i,
  output logic          expire_o
);
  logic [RW-1:0] cnt_q;

  assign expire_o = cnt_q == RW'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (!hold_i) begin
      if (load_i || expire_o) begin
        cnt_q <= rate_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - RW'(1);
      end
    end
  end
endmodule

// File: rtl/sweep_addr.sv
module sweep_addr
  import sweep_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              hold_i,
  input  logic              restart_i,
  input  logic              expire_i,
  input  logic              dir_i,
  input  logic              flip_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [AW-1:0]     begin_i,
  input  logic [AW-1:0]     final_i,
  output logic [AW-1:0]     addr_o,
  output logic              step_o,
  output logic              end_o,
  output logic              run_o
);
  logic [AW-1:0] addr_n;
  logic          up_q;
  logic          up_n;
  logic          run_n;
  logic          end_n;
  logic          at_top;
  logic          at_bot;

  assign at_top = addr_o == final_i;
  assign at_bot = addr_o == begin_i;

  always_comb begin
    addr_n = addr_o;
    up_n   = up_q;
    run_n  = run_o;
    if (restart_i) begin
      addr_n = begin_i;
      up_n   = 1'b1;
      run_n  = 1'b1;
    end else if (run_o) begin
      unique case (mode_i)
        SEG_STEER: begin
          if (flip_i || expire_i) begin
            if (dir_i && !at_top) begin
              addr_n = addr_o + AW'(1);
            end else if (!dir_i && !at_bot) begin
              addr_n = addr_o - AW'(1);
            end
          end
        end
        SEG_BOUNCE: begin
          if (expire_i) begin
            if (up_q) begin
              if (!at_top) begin
                addr_n = addr_o + AW'(1);
                up_n   = (addr_n != final_i);
              end
            end else if (!at_bot) begin
              addr_n = addr_o - AW'(1);
              up_n   = (addr_n == begin_i);
            end
          end
        end
        SEG_WRAP: begin
          if (expire_i) begin
            addr_n = at_top ? begin_i : addr_o + AW'(1);
          end
        end
        default: begin
          if (expire_i && !at_top) begin
            addr_n = addr_o + AW'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    end_n = 1'b0;
    if (run_n) begin
      if (is_steer(mode_i)) begin
        end_n = dir_i ? (addr_n == final_i) : (addr_n == begin_i);
      end else if (is_ramp(mode_i)) begin
        end_n = addr_n == final_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      addr_o <= '0;
      up_q   <= 1'b1;
      run_o  <= 1'b0;
      step_o <= 1'b0;
      end_o  <= 1'b0;
    end else if (hold_i) begin
      step_o <= 1'b0;
    end else begin
      addr_o <= addr_n;
      up_q   <= up_n;
      run_o  <= run_n;
      step_o <= !restart_i && (addr_n != addr_o);
      end_o  <= end_n;
    end
  end
endmodule

// File: rtl/ram_sweep_gen.sv
module ram_sweep_gen
  import sweep_pkg::*;
#(
  parameter int NPROF = 4,
  parameter int AW    = 10,
  parameter int RW    = 16,
  localparam int PW   = (NPROF > 1) ? $clog2(NPROF) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    ram_en_i,
  input  logic                    update_i,
  input  logic [PW-1:0]           prof_sel_i,
  input  logic                    dir_i,
  input  logic [NPROF*MODE_W-1:0] seg_mode_i,
  input  logic [NPROF*AW-1:0]     seg_begin_i,
  input  logic [NPROF*AW-1:0]     seg_final_i,
  input  logic [NPROF*RW-1:0]     seg_rate_i,
  output logic [AW-1:0]           addr_o,
  output logic                    step_o,
  output logic                    end_o
);
  logic              upd_rise_w;
  logic [PW-1:0]     prof_w;
  logic              restart_w;
  logic              dir_flip_w;
  logic              lock_w;
  logic [MODE_W-1:0] cur_mode_w;
  logic [AW-1:0]     cur_begin_w;
  logic [AW-1:0]     cur_final_w;
  logic [RW-1:0]     cur_rate_w;
  logic              expire_w;
  logic              running_w;
  logic              hold_w;
  logic              tmr_load_w;

  assign hold_w     = ~ram_en_i;
  assign tmr_load_w = restart_w | (is_steer(cur_mode_w) & running_w & dir_flip_w);

  sweep_ctrl #(.PW(PW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .ram_en_i   (ram_en_i),
    .update_i   (update_i),
    .prof_sel_i (prof_sel_i),
    .dir_i      (dir_i),
    .lock_i     (lock_w),
    .upd_rise_o (upd_rise_w),
    .prof_o     (prof_w),
    .restart_o  (restart_w),
    .dir_flip_o (dir_flip_w)
  );

  sweep_bank #(.NPROF(NPROF), .AW(AW), .RW(RW), .PW(PW)) u_bank (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .load_i      (upd_rise_w),
    .mode_i      (seg_mode_i),
    .begin_i     (seg_begin_i),
    .final_i     (seg_final_i),
    .rate_i      (seg_rate_i),
    .sel_i       (prof_w),
    .cur_mode_o  (cur_mode_w),
    .cur_begin_o (cur_begin_w),
    .cur_final_o (cur_final_w),
    .cur_rate_o  (cur_rate_w),
    .lock_o      (lock_w)
  );

  sweep_timer #(.RW(RW)) u_timer (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .hold_i   (hold_w),
    .load_i   (tmr_load_w),
    .rate_i   (cur_rate_w),
    .expire_o (expire_w)
  );

  sweep_addr #(.AW(AW)) u_addr (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .hold_i    (hold_w),
    .restart_i (restart_w),
    .expire_i  (expire_w),
    .dir_i     (dir_i),
    .flip_i    (dir_flip_w),
    .mode_i    (cur_mode_w),
    .begin_i   (cur_begin_w),
    .final_i   (cur_final_w),
    .addr_o    (addr_o),
    .step_o    (step_o),
    .end_o     (end_o),
    .run_o     (running_w)
  );
endmodule

// File: rtl/sweep_chk.sv
module sweep_chk #(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          ram_en_i,
  input logic [AW-1:0] addr_o,
  input logic          step_o,
  input logic          end_o,
  input logic          restart_i,
  input logic          run_i
);
  // R1: reset leaves the outputs idle
  a_r1_reset_idle: assert property (@(posedge clk_i)
    rst_i |=> (addr_o == '0 && !step_o && !end_o));

  // R1: nothing moves or flags before a sweep is started
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |-> (!step_o && !end_o));

  // R2: the load cycle is not a step
  a_r2_load_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_i |=> !step_o);

  // R4: a step strobe always goes with an address change
  a_r4_step_moves: assert property (@(posedge clk_i) disable iff (rst_i)
    step_o |-> (addr_o != $past(addr_o)));

  // R12: disabled sweep holds its address
  a_r12_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!ram_en_i) |-> ($stable(addr_o) && !step_o));
endmodule

bind ram_sweep_gen sweep_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .ram_en_i  (ram_en_i),
  .addr_o    (addr_o),
  .step_o    (step_o),
  .end_o     (end_o),
  .restart_i (restart_w),
  .run_i     (running_w)
);

// File: tb/test_ram_sweep_gen.sv
module test_ram_sweep_gen;
  localparam int CLK_P = 10;
  localparam int NP = 4;
  localparam int AW = 10;
  localparam int RW = 16;

  typedef struct {
    logic [AW-1:0] addr;
    logic          step;
    logic          fin;
    string         tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst;
  logic            ram_en;
  logic            update;
  logic [1:0]      prof_sel;
  logic            dir;
  logic [NP*3-1:0] seg_mode;
  logic [NP*AW-1:0] seg_begin;
  logic [NP*AW-1:0] seg_final;
  logic [NP*RW-1:0] seg_rate;
  logic [AW-1:0]   addr;
  logic            step;
  logic            fin;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  exp_t q[$];

  // model state, named after the requirements rather than the RTL
  logic [2:0]    m_mode [NP];
  logic [AW-1:0] m_beg  [NP];
  logic [AW-1:0] m_fin  [NP];
  logic [RW-1:0] m_rate [NP];
  logic          m_upd, m_dir, m_rq, m_run, m_up, m_step, m_end;
  logic [1:0]    m_prof;
  logic [AW-1:0] m_addr;
  logic [RW-1:0] m_cnt;

  always #(CLK_P/2) clk = ~clk;

  ram_sweep_gen i_ram_sweep_gen (
    .clk_i(clk), .rst_i(rst), .ram_en_i(ram_en), .update_i(update),
    .prof_sel_i(prof_sel), .dir_i(dir), .seg_mode_i(seg_mode),
    .seg_begin_i(seg_begin), .seg_final_i(seg_final), .seg_rate_i(seg_rate),
    .addr_o(addr), .step_o(step), .end_o(fin)
  );

  // expected state after the coming clock edge
  task automatic model_eval(input string tag);
    exp_t it;
    logic [2:0] cm;
    logic [AW-1:0] cb, cf, na;
    logic [RW-1:0] cr;
    logic lock, rise, flip, nu, nr, tick_now;
    logic [1:0] eff;
    if (rst) begin
      for (int p = 0; p < NP; p++) begin
        m_mode[p] = 0; m_beg[p] = 0; m_fin[p] = 0; m_rate[p] = 0;
      end
      m_upd = 0; m_dir = 0; m_rq = 0; m_run = 0; m_up = 1; m_step = 0; m_end = 0;
      m_prof = 0; m_addr = 0; m_cnt = 0;
    end else begin
      lock = (m_mode[0] == 3'b001);
      eff  = lock ? 2'd0 : m_prof;
      cm = m_mode[eff]; cb = m_beg[eff]; cf = m_fin[eff];
      cr = (m_rate[eff] == 0) ? RW'(1) : m_rate[eff];
      rise = update && !m_upd;
      flip = dir != m_dir;
      if (ram_en) begin
        na = m_addr; nu = m_up; nr = m_run;
        if (m_rq) begin
          na = cb; nu = 1; nr = 1; m_cnt = cr;
        end else begin
          tick_now = (m_cnt == 1);
          if (m_run) begin
            case (cm)
              3'b001: if (flip || tick_now) begin
                if (dir && m_addr != cf) na = m_addr + 1;
                else if (!dir && m_addr != cb) na = m_addr - 1;
              end
              3'b011: if (tick_now) begin
                if (m_up) begin
                  if (m_addr != cf) begin na = m_addr + 1; if (na == cf) nu = 0; end
                end else if (m_addr != cb) begin
                  na = m_addr - 1; if (na == cb) nu = 1;
                end
              end
              3'b100: if (tick_now) na = (m_addr == cf) ? cb : m_addr + 1;
              default: if (tick_now && m_addr != cf) na = m_addr + 1;
            endcase
          end
          if ((cm == 3'b001 && m_run && flip) || tick_now) m_cnt = cr;
          else if (m_cnt != 0) m_cnt = m_cnt - 1;
        end
        m_step = !m_rq && (na != m_addr);
        if (!nr) m_end = 0;
        else if (cm == 3'b001) m_end = dir ? (na == cf) : (na == cb);
        else if (cm == 3'b011 || cm == 3'b100) m_end = 0;
        else m_end = (na == cf);
        m_addr = na; m_up = nu; m_run = nr;
      end else begin
        m_step = 0;
      end
      m_rq = ram_en && (rise || (prof_sel != m_prof && !lock));
      if (rise) begin
        for (int p = 0; p < NP; p++) begin
          m_mode[p] = seg_mode[p*3 +: 3];
          m_beg[p]  = seg_begin[p*AW +: AW];
          m_fin[p]  = seg_final[p*AW +: AW];
          m_rate[p] = seg_rate[p*RW +: RW];
        end
      end
      m_upd = update; m_prof = prof_sel; m_dir = dir;
    end
    it.addr = m_addr; it.step = m_step; it.fin = m_end; it.tag = tag;
    q.push_back(it);
  endtask

  // driver: one item per clock, inputs already set for the coming edge
  task automatic tick(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      model_eval(tag);
      @(negedge clk);
    end
  endtask

  task automatic set_prof(input int p, input logic [2:0] md, input int b, input int f, input int r);
    seg_mode[p*3 +: 3]    = md;
    seg_begin[p*AW +: AW] = AW'(b);
    seg_final[p*AW +: AW] = AW'(f);
    seg_rate[p*RW +: RW]  = RW'(r);
  endtask

  task automatic pulse_upd(input string tag);
    update = 1; tick(1, tag);
    update = 0; tick(1, tag);
  endtask

  // monitor: compare a quarter period after each rising edge
  always @(posedge clk) begin
    exp_t it;
    #(CLK_P/4);
    if (q.size() != 0) begin
      it = q.pop_front();
      checks++;
      if (addr !== it.addr || step !== it.step || fin !== it.fin) begin
        failures++;
        $display("FAIL %s: addr/step/end actual=%0d/%0b/%0b expected=%0d/%0b/%0b",
                 it.tag, addr, step, fin, it.addr, it.step, it.fin);
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; ram_en = 0; update = 0; prof_sel = 0; dir = 0;
    seg_mode = '0; seg_begin = '0; seg_final = '0; seg_rate = '0;
    tick(3, "R1 reset");
    rst = 0; ram_en = 1;
    tick(4, "R1 idle");

    // R2: level held high restarts only once; R5 climb and park; R4 pacing of 2
    set_prof(0, 3'b000, 3, 6, 2);
    update = 1; tick(3, "R2 edge");
    update = 0; tick(14, "R4 R5 ramp");

    // R3 profile switch, R10 wraparound, R4 interval 0 treated as 1
    set_prof(1, 3'b100, 10, 12, 0);
    pulse_upd("R2 load");
    prof_sel = 1; tick(10, "R3 R10 R4 wrap");

    // R9 triangle
    set_prof(2, 3'b011, 20, 23, 1);
    pulse_upd("R2 load");
    prof_sel = 2; tick(16, "R9 R3 bounce");

    // R5 unused code behaves as ramp
    set_prof(3, 3'b110, 5, 7, 3);
    pulse_upd("R2 load");
    prof_sel = 3; tick(14, "R5 unused code");

    // R6 steered sweep with stall at the top
    set_prof(0, 3'b001, 40, 43, 3);
    dir = 1;
    pulse_upd("R8 lock");
    tick(14, "R6 steer up");
    dir = 0; tick(2, "R7 flip");
    dir = 1; tick(1, "R7 flip");
    dir = 0; tick(1, "R7 flip");
    dir = 1; tick(3, "R7 flip");
    dir = 0; tick(16, "R6 steer down");
    prof_sel = 1; tick(4, "R8 select ignored");
    set_prof(0, 3'b001, 100, 110, 3);
    dir = 1; tick(6, "R11 dir no load");
    dir = 0; tick(3, "R11 dir no load");
    pulse_upd("R2 load");
    tick(4, "R2 new words");

    // R12 freeze with dropped restart
    set_prof(0, 3'b011, 60, 63, 1);
    pulse_upd("R2 load");
    tick(4, "R9 bounce");
    ram_en = 0; tick(2, "R12 frozen");
    prof_sel = 2; tick(2, "R12 frozen");
    dir = 1; tick(2, "R12 frozen");
    ram_en = 1; tick(8, "R12 resume");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule